// File: doc/BRIEF.md
# Trace ID Filter Register Bank

This block stands between one trace source and two trace sinks. A single upstream stream carries beats of data tagged with a 7-bit trace ID. Each sink has its own 128-bit allow mask, one bit per trace ID. A beat goes to every sink whose mask has that ID's bit set. A beat that no sink wants is consumed upstream and discarded, so the filter never holds the source back for a beat it throws away. When a beat is wanted by several sinks it is handed to all of them in the same cycle, or to none of them. It is never delivered to one sink and held back for another.

Software sets up the masks through a simple APB-style register port. The port uses a single-cycle access phase and has no wait states. Each sink's mask takes four consecutive 32-bit words. A lock register guards the masks: writes to them take effect only after the unlock key has been written. The usual sequence is to unlock, update the words, and relock. Trace ID 0 and the top sixteen IDs are reserved. They never reach any sink, whatever the mask bits say.

Top module: `trace_id_gate`

## Requirements
- R1: After reset every mask bit is zero and the block is locked, so every incoming beat is consumed (in_ready high) and no out_valid bit is set.
- R2: Trace ID n is controlled by bit (n mod 32) of mask word (n div 32). Sink 0's word k sits at byte address 0x0F8 + 4k, and sink 1's word k sits at 0x108 + 4k. A read of a mask word returns its stored value.
- R3: The lock register is at 0xFB0. Writing 0xC5ACCE55 to it unlocks the block, and writing any other value locks it. A read returns the lock state in bit 0, where 1 means locked.
- R4: While the block is locked, writes to the mask words leave them unchanged, and reads still return the stored values.
- R5: Any address that is neither the lock register nor one of the eight mask words raises pslverr in the access phase. This covers addresses just outside a group and misaligned addresses. Such a read returns 0, and such a write changes no state.
- R6: A beat whose ID bit is set in a sink's mask is presented to that sink on out_valid[s], with out_id and out_data equal to the input.
- R7: Beats with ID 0x00 or with an ID from 0x70 to 0x7F never raise any out_valid bit.
- R8: A beat that no sink accepts gets in_ready high in the same cycle, even when every out_ready bit is low.
- R9: A beat accepted by several sinks is handshaked atomically. in_ready is high only when every accepting sink is ready. out_valid[s] is raised only when every other accepting sink is also ready.
- R10: A mask word written in one access phase governs beats from the next clock cycle on. A beat presented during that access phase still sees the old mask.
- R11: Writing zero to a mask word clears all 32 IDs it holds, and beats with those IDs are then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Unmapped-address error, valid in the access phase |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat consumed |
| in_id | input | 7 | Trace ID of the upstream beat |
| in_data | input | 32 | Upstream beat payload |
| out_valid | output | 2 | Per-sink beat valid |
| out_ready | input | 2 | Per-sink ready |
| out_id | output | 7 | Trace ID presented to the sinks |
| out_data | output | 32 | Payload presented to the sinks |

## Verification
The register port answers combinationally: prdata and pslverr are due in the same access-phase cycle, and a written value becomes visible from the following clock edge. The stream path has no register at all, so out_valid, in_ready and the payload follow the inputs in the same cycle, against whichever mask was registered at the last edge. The bench drives every input on the falling edge and samples 1 ns later, before the next rising edge. An access-phase check therefore sees the pre-write state. The R10 check places a beat in that same window and repeats it one cycle later to see the new mask take effect. Each trace ID from 0 to 127 is swept under three mask patterns, with the out_ready pair rotated through all four combinations.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
    localparam int SINKS       = 2;
    localparam int GROUP_WORDS = 4;
    localparam int REG_W       = 32;
    localparam int ID_W        = 7;
    localparam int MASK_BITS   = GROUP_WORDS * REG_W;
    localparam int ALL_WORDS   = SINKS * GROUP_WORDS;
    localparam logic [REG_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
    localparam logic [ID_W-1:0]  RSVD_HIGH  = 7'h70;

    typedef struct packed {
        logic                              locked;
        logic [ALL_WORDS-1:0][REG_W-1:0]   mask;
    } cfg_state_t;

    function automatic logic id_reserved(input logic [ID_W-1:0] id);
        return (id == '0) || (id >= RSVD_HIGH);
    endfunction
endpackage

// File: rtl/tgate_regs.sv
module tgate_regs
    import tgate_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] SINK0_BASE = 12'h0F8,
    parameter logic [ADDR_W-1:0] SINK1_BASE = 12'h108,
    parameter logic [ADDR_W-1:0] LOCK_ADDR  = 12'hFB0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [REG_W-1:0]            pwdata,
    output logic [REG_W-1:0]            prdata,
    output logic                        pslverr,
    output logic [ALL_WORDS*REG_W-1:0]  mask_flat,
    output logic                        locked
);
    localparam logic [ADDR_W-1:0] BASES [SINKS] = '{SINK0_BASE, SINK1_BASE};

    cfg_state_t st_d, st_q;
    logic       access;
    logic       hit_any;
    logic [REG_W-1:0] rd_word;

    always_comb begin
        st_d    = st_q;
        access  = psel & penable;
        hit_any = 1'b0;
        rd_word = '0;

        if (paddr == LOCK_ADDR) begin
            hit_any = 1'b1;
            rd_word = {{(REG_W-1){1'b0}}, st_q.locked};
            if (access && pwrite) begin
                st_d.locked = (pwdata != UNLOCK_KEY);
            end
        end

        for (int s = 0; s < SINKS; s++) begin
            for (int w = 0; w < GROUP_WORDS; w++) begin
                if (paddr == BASES[s] + ADDR_W'(w * 4)) begin
                    hit_any = 1'b1;
                    rd_word = st_q.mask[s*GROUP_WORDS + w];
                    if (access && pwrite && !st_q.locked) begin
                        st_d.mask[s*GROUP_WORDS + w] = pwdata;
                    end
                end
            end
        end

        prdata  = access ? rd_word : '0;
        pslverr = access & ~hit_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
            st_q.mask   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_flat = st_q.mask;
    assign locked    = st_q.locked;
endmodule

// File: rtl/tgate_lookup.sv
module tgate_lookup
    import tgate_pkg::*;
(
    input  logic [MASK_BITS-1:0] mask,
    input  logic [ID_W-1:0]      id,
    output logic                 allow
);
    always_comb begin
        allow = mask[id] & ~id_reserved(id);
    end
endmodule

// File: rtl/tgate_fork.sv
module tgate_fork
    import tgate_pkg::*;
(
    input  logic             in_valid,
    input  logic [SINKS-1:0] allow,
    input  logic [SINKS-1:0] out_ready,
    output logic [SINKS-1:0] out_valid,
    output logic             in_ready
);
    logic [SINKS-1:0] ok;

    always_comb begin
        // a sink is "ok" when it either does not want the beat or can take it
        ok       = ~allow | out_ready;
        in_ready = &ok;
        for (int i = 0; i < SINKS; i++) begin
            out_valid[i] = in_valid & allow[i] & (&(ok | (SINKS'(1) << i)));
        end
    end
endmodule

// File: rtl/trace_id_gate.sv
module trace_id_gate
    import tgate_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                TDATA_W    = 32,
    parameter logic [ADDR_W-1:0] SINK0_BASE = 12'h0F8,
    parameter logic [ADDR_W-1:0] SINK1_BASE = 12'h108,
    parameter logic [ADDR_W-1:0] LOCK_ADDR  = 12'hFB0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pslverr,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [6:0]         in_id,
    input  logic [TDATA_W-1:0] in_data,
    output logic [1:0]         out_valid,
    input  logic [1:0]         out_ready,
    output logic [6:0]         out_id,
    output logic [TDATA_W-1:0] out_data
);
    logic [ALL_WORDS*REG_W-1:0] mask_flat;
    logic                       locked;
    logic [SINKS-1:0]           allow;

    tgate_regs #(
        .ADDR_W    (ADDR_W),
        .SINK0_BASE(SINK0_BASE),
        .SINK1_BASE(SINK1_BASE),
        .LOCK_ADDR (LOCK_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pslverr  (pslverr),
        .mask_flat(mask_flat),
        .locked   (locked)
    );

    for (genvar s = 0; s < SINKS; s++) begin : g_sink
        tgate_lookup u_lookup (
            .mask (mask_flat[s*MASK_BITS +: MASK_BITS]),
            .id   (in_id),
            .allow(allow[s])
        );
    end

    tgate_fork u_fork (
        .in_valid (in_valid),
        .allow    (allow),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .in_ready (in_ready)
    );

    assign out_id   = in_id;
    assign out_data = in_data;
endmodule

// File: rtl/tgate_checker.sv
module tgate_checker
    import tgate_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hFB0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       psel,
    input logic                       penable,
    input logic                       pwrite,
    input logic [ADDR_W-1:0]          paddr,
    input logic [31:0]                pwdata,
    input logic                       pslverr,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [6:0]                 in_id,
    input logic [1:0]                 out_valid,
    input logic [1:0]                 out_ready,
    input logic [ALL_WORDS*REG_W-1:0] mask_flat,
    input logic                       locked
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_flat == '0) && locked); // R1

    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pwrite && (paddr == LOCK_ADDR) && (pwdata == UNLOCK_KEY)
        |=> !locked); // R3

    AST_LOCKED_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pwrite && locked && (paddr != LOCK_ADDR)
        |=> $stable(mask_flat)); // R4

    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pslverr |=> $stable(mask_flat) && $stable(locked)); // R5

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != 2'b00) |-> in_valid); // R6

    AST_RESERVED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_id == 7'h00) || (in_id >= 7'h70))
        |-> (out_valid == 2'b00) && in_ready); // R7

    AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & out_ready) != 2'b00) |-> in_ready); // R9
endmodule

bind trace_id_gate tgate_checker #(
    .ADDR_W   (ADDR_W),
    .LOCK_ADDR(LOCK_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .pslverr  (pslverr),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_id    (in_id),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .mask_flat(mask_flat),
    .locked   (locked)
);

// File: tb/trace_id_gate_test.sv
`timescale 1ns/1ps
module trace_id_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pslverr;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [6:0]  in_id = '0;
    logic [31:0] in_data = '0;
    logic [1:0]  out_valid;
    logic [1:0]  out_ready = 2'b00;
    logic [6:0]  out_id;
    logic [31:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] em [8];   // expected mask words: sink s word k at index s*4+k

    always #4 clk = ~clk;  // 125 MHz

    trace_id_gate uut (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_data(out_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] word_addr(input int idx);
        return (idx < 4) ? 12'(12'h0F8 + idx * 4) : 12'(12'h108 + (idx - 4) * 4);
    endfunction

    function automatic logic exp_allow(input int s, input int id);
        if (id == 0 || id >= 112) return 1'b0;
        return em[s*4 + id/32][id%32];
    endfunction

    task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr_reg(input string tag, input logic [11:0] a, input logic [31:0] d,
                          input logic exp_err);
        logic [31:0] rd; logic err;
        apb(1'b1, a, d, rd, err);
        chk(tag, {31'b0, err}, {31'b0, exp_err});
    endtask

    task automatic rd_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic err;
        apb(1'b0, a, 32'h0, rd, err);
        chk(tag, rd, exp);
    endtask

    task automatic readback_all(input string tag);
        for (int k = 0; k < 8; k++) rd_reg(tag, word_addr(k), em[k]);
    endtask

    task automatic beat(input string tag, input int id, input logic [1:0] rdy);
        logic a0, a1, ok0, ok1;
        logic [2:0] exp_v;
        @(negedge clk);
        in_valid = 1'b1; in_id = 7'(id); in_data = 32'hA5A5_0000 ^ 32'(id * 77);
        out_ready = rdy;
        #1;
        a0 = exp_allow(0, id); a1 = exp_allow(1, id);
        ok0 = ~a0 | rdy[0]; ok1 = ~a1 | rdy[1];
        exp_v = {a1 & ok0, a0 & ok1, ok0 & ok1};
        chk(tag, {29'b0, out_valid, in_ready}, {29'b0, exp_v});
        if (out_valid != 2'b00) chk(tag, {out_data[24:0], out_id}, {in_data[24:0], in_id});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd; logic err;
        for (int k = 0; k < 8; k++) em[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd_reg("R1 lock state", 12'hFB0, 32'h1);
        readback_all("R1 mask zero");
        beat("R1 drop at reset", 5, 2'b00);
        beat("R1 drop at reset", 64, 2'b11);
        @(negedge clk); in_valid = 1'b0;

        // R3: unlock
        wr_reg("R3 unlock", 12'hFB0, 32'hC5AC_CE55, 1'b0);
        rd_reg("R3 unlocked", 12'hFB0, 32'h0);

        // sweep: R2 layout, R6..R9 filtering
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 8; k++) begin
                case (p)
                    0: em[k] = 32'h9E37_79B9 * 32'(k + 1);
                    1: em[k] = 32'hFFFF_FFFF;
                    default: em[k] = (k < 4) ? 32'h5555_5555 << k : 32'hF0F0_F0F0 >> k;
                endcase
                wr_reg("R2 write", word_addr(k), em[k], 1'b0);
            end
            readback_all("R2 readback");
            for (int id = 0; id < 128; id++) begin
                beat("R6 R7 R8 R9 sweep", id, 2'(id) ^ 2'(p));
            end
            @(negedge clk); in_valid = 1'b0;
        end

        // R9: both accept, one stalled
        beat("R9 sink1 stalled", 40, 2'b01);
        beat("R9 sink0 stalled", 40, 2'b10);
        beat("R9 both ready", 40, 2'b11);
        beat("R8 dropped never stalls", 0, 2'b00);
        @(negedge clk); in_valid = 1'b0;

        // R11: clear everything by writing zeros
        for (int k = 0; k < 8; k++) begin
            em[k] = '0;
            wr_reg("R11 clear", word_addr(k), 32'h0, 1'b0);
        end
        beat("R11 cleared id dropped", 37, 2'b11);
        beat("R11 cleared id dropped", 100, 2'b00);
        @(negedge clk); in_valid = 1'b0;

        // R10: write takes effect the cycle after the access phase
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h0FC; pwdata = 32'h20;
        in_valid = 1'b1; in_id = 7'd37; in_data = 32'h1234_5678; out_ready = 2'b11;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk("R10 old mask during write", {30'b0, out_valid}, 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        chk("R10 new mask next cycle", {30'b0, out_valid}, 32'h1);
        em[1] = 32'h20;
        beat("R10 new mask", 37, 2'b11);
        @(negedge clk); in_valid = 1'b0;

        // R4: locked writes ignored
        wr_reg("R3 relock", 12'hFB0, 32'h0, 1'b0);
        rd_reg("R3 locked", 12'hFB0, 32'h1);
        wr_reg("R4 locked write", 12'h108, 32'hFFFF_FFFF, 1'b0);
        wr_reg("R4 locked write", 12'h0FC, 32'h0, 1'b0);
        readback_all("R4 unchanged");
        beat("R4 filter unchanged", 37, 2'b11);
        beat("R4 filter unchanged", 5, 2'b11);
        @(negedge clk); in_valid = 1'b0;

        // R5: unmapped / out-of-group / misaligned
        wr_reg("R3 unlock again", 12'hFB0, 32'hC5AC_CE55, 1'b0);
        wr_reg("R5 below group", 12'h0F4, 32'hFFFF_FFFF, 1'b1);
        wr_reg("R5 past group", 12'h118, 32'hFFFF_FFFF, 1'b1);
        wr_reg("R5 misaligned", 12'h0FA, 32'hFFFF_FFFF, 1'b1);
        apb(1'b0, 12'h000, 32'h0, rd, err);
        chk("R5 read error", {31'b0, err}, 32'h1);
        chk("R5 read zero", rd, 32'h0);
        readback_all("R5 unchanged");
        rd_reg("R5 lock unchanged", 12'hFB0, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule